// File: doc/BRIEF.md
# Data-Capturing Reservation Station

This block is the operand-collecting instruction buffer that sits in front of one functional unit in an out-of-order core. Dispatch hands it one instruction per cycle. Each of the two source operands arrives either as a value or as the tag of a result that is still being produced. The station holds up to `DEPTH` instructions. Every cycle it compares each pending tag against all `NBUS` result-forwarding buses and latches a value when a tag matches. Among the entries whose operands are complete, it issues the oldest one to the unit, at most one per cycle. An entry can issue in the very cycle its last operand is broadcast, because the broadcast value is passed straight to the issue port.

Dispatch can mark an instruction as able to raise an exception, for example a load that may miss. Such an entry is not released when it issues. It stays in a held state until the unit either reports a clean finish, which frees the entry, or asks for a replay, which makes the entry selectable again with the operands it captured. A flush empties the whole station in one cycle. Dispatch must stop sending while the stall output is high.

Each entry is a four-state machine. The states are FREE, WAIT (at least one operand still pending), RDY (both operands present) and HELD (issued and kept for a possible replay). The transitions are:
- ALLOC: FREE to WAIT or RDY.
- WAKE: WAIT to RDY.
- ISSUE_FREE: WAIT or RDY to FREE.
- ISSUE_HOLD: WAIT or RDY to HELD.
- REPLAY: HELD to RDY.
- DONE: HELD to FREE.
- FLUSH: any state to FREE.

Age is kept as a rank per entry. Rank 0 marks the oldest busy entry. When an entry is freed, every younger entry moves down by one, so the busy entries always hold the ranks 0 to n-1.

Top module: `rs_station`

## Requirements
- R1: After reset, and in the cycle after a flush, every entry is FREE, `disp_stall` is 0 and `iss_valid` is 0.
- R2: An accepted dispatch (`disp_valid` high while `disp_stall` is low and `flush` is low) goes to the lowest-numbered FREE entry. `disp_stall` is high exactly when all `DEPTH` entries are busy, and a dispatch offered while it is high is dropped.
- R3: An operand dispatched with its ok bit set is kept as given. A pending operand latches `fwd_data` of a bus whose `fwd_valid` is set and whose `fwd_tag` equals the pending tag. When more than one bus matches, the lowest-numbered bus wins. The latched values appear on `iss_a` and `iss_b`.
- R4: A pending operand whose tag is broadcast in the same cycle as its dispatch is captured in that cycle.
- R5: An entry whose operands were complete at dispatch can issue no earlier than the following cycle. A WAIT entry can issue in the same cycle its last pending operand is broadcast, and in that case the broadcast value is driven on the issue port.
- R6: When several entries are eligible, the one dispatched earliest issues. At most one instruction issues per cycle, and `iss_slot` names its entry.
- R7: An issued entry whose may-except flag is 0 is FREE in the next cycle. One whose flag is 1 moves to HELD, stays busy and is never selected while held.
- R8: `rpl_valid` naming a HELD entry returns it to RDY with the operands it captured. `fin_valid` naming a HELD entry frees it. Both are ignored for an entry that is not HELD. When both name the same HELD entry in one cycle, the finish wins.
- R9: `flush` frees every entry at the next edge. A dispatch offered in the flush cycle is dropped, and `iss_valid` is 0 during the flush cycle.
- R10: `iss_held` equals the may-except flag given at dispatch to the instruction being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Free all entries |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_op | input | OP_W | Operation code carried to the unit |
| disp_may_exc | input | 1 | Instruction may raise an exception; keep its entry after issue |
| disp_a_ok | input | 1 | Operand A is a value (1) or a pending tag (0) |
| disp_a_val | input | DATA_W | Operand A value |
| disp_a_tag | input | TAG_W | Operand A producer tag |
| disp_b_ok | input | 1 | Operand B is a value (1) or a pending tag (0) |
| disp_b_val | input | DATA_W | Operand B value |
| disp_b_tag | input | TAG_W | Operand B producer tag |
| disp_dst | input | TAG_W | Destination tag carried to the unit |
| disp_stall | output | 1 | All entries busy; dispatch must wait |
| fwd_valid | input | NBUS | Per-bus broadcast strobe |
| fwd_tag | input | NBUS*TAG_W | Bus tags, bus k at bits k*TAG_W upward |
| fwd_data | input | NBUS*DATA_W | Bus values, bus k at bits k*DATA_W upward |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_slot | output | IDX_W | Entry being issued |
| iss_op | output | OP_W | Operation code of the issued instruction |
| iss_a | output | DATA_W | Operand A of the issued instruction |
| iss_b | output | DATA_W | Operand B of the issued instruction |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |
| iss_held | output | 1 | Issued entry is kept for a possible replay |
| fin_valid | input | 1 | The unit finished a held instruction cleanly |
| fin_slot | input | IDX_W | Entry that finished |
| rpl_valid | input | 1 | The unit requests a replay |
| rpl_slot | input | IDX_W | Entry to replay |

## Verification
The first pattern fills the station with operands that are all pending, which separates the full/stall boundary from issue. Tags are then broadcast out of dispatch order and two at a time, so age ordering can be told apart from slot-index ordering, and same-cycle bypass can be told apart from issue one cycle after capture. A tag broadcast in the dispatch cycle shows whether the dispatch path snoops the buses. The held-entry sequence sends a finish to a non-held entry, a replay, and then a finish together with a replay, which separates the HELD transitions from one another. A long random mix of dispatch, two-bus broadcast, finish, replay and rare flush, using a small tag space so that matches are frequent, is compared every clock against a queue-free behavioural model.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_RDY  = 2'd2,
        ENT_HELD = 2'd3
    } rs_ent_e;

endpackage

// File: rtl/rs_snoop.sv
// Tag comparator across all forwarding buses; lowest bus wins on multiple hits.
module rs_snoop #(
    parameter int NBUS   = 2,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic [TAG_W-1:0]       tag_i,
    input  logic [NBUS-1:0]        fwd_valid,
    input  logic [NBUS*TAG_W-1:0]  fwd_tag,
    input  logic [NBUS*DATA_W-1:0] fwd_data,
    output logic                   hit_o,
    output logic [DATA_W-1:0]      data_o
);

    always_comb begin
        hit_o  = 1'b0;
        data_o = '0;
        for (int b = NBUS - 1; b >= 0; b--) begin
            if (fwd_valid[b] && (fwd_tag[b*TAG_W +: TAG_W] == tag_i)) begin
                hit_o  = 1'b1;
                data_o = fwd_data[b*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/rs_alloc.sv
// Free-entry priority encoder and stall generation.
module rs_alloc #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] busy_i,
    output logic [IDX_W-1:0] free_idx_o,
    output logic             full_o
);

    always_comb begin
        free_idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                free_idx_o = IDX_W'(i);
            end
        end
    end

    assign full_o = &busy_i;

endmodule

// File: rtl/rs_select.sv
// Oldest-first select: smallest rank among eligible entries.
module rs_select #(
    parameter int DEPTH = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int RANK_W = IDX_W
) (
    input  logic [DEPTH-1:0]        cand_i,
    input  logic [DEPTH*RANK_W-1:0] rank_i,
    input  logic                    en_i,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic [DEPTH-1:0]        grant_o
);

    logic              found;
    logic [RANK_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand_i[i] && (!found || (rank_i[i*RANK_W +: RANK_W] < best))) begin
                found = 1'b1;
                best  = rank_i[i*RANK_W +: RANK_W];
                idx_o = IDX_W'(i);
            end
        end
    end

    always_comb begin
        grant_o = '0;
        valid_o = found && en_i;
        if (found && en_i) begin
            grant_o[idx_o] = 1'b1;
        end
    end

endmodule

// File: rtl/rs_entry.sv
// One reservation entry: state machine, operand capture, age rank.
module rs_entry
    import rs_pkg::*;
#(
    parameter int NBUS   = 2,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int RANK_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   alloc_i,
    input  logic [OP_W-1:0]        d_op,
    input  logic                   d_exc,
    input  logic                   d_a_ok,
    input  logic [DATA_W-1:0]      d_a_val,
    input  logic [TAG_W-1:0]       d_a_tag,
    input  logic                   d_b_ok,
    input  logic [DATA_W-1:0]      d_b_val,
    input  logic [TAG_W-1:0]       d_b_tag,
    input  logic [TAG_W-1:0]       d_dst,
    input  logic [RANK_W-1:0]      d_rank,
    input  logic [NBUS-1:0]        fwd_valid,
    input  logic [NBUS*TAG_W-1:0]  fwd_tag,
    input  logic [NBUS*DATA_W-1:0] fwd_data,
    input  logic                   grant_i,
    input  logic                   fin_hit_i,
    input  logic                   rpl_hit_i,
    input  logic [RANK_W-1:0]      rank_dec_i,
    output logic                   busy_o,
    output logic                   held_o,
    output logic                   cand_o,
    output logic                   leave_o,
    output logic [DATA_W-1:0]      a_o,
    output logic [DATA_W-1:0]      b_o,
    output logic [OP_W-1:0]        op_o,
    output logic [TAG_W-1:0]       dst_o,
    output logic                   exc_o,
    output logic [RANK_W-1:0]      rank_o
);

    rs_ent_e           st_q, st_d;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;
    logic              exc_q;
    logic              a_v_q, b_v_q;
    logic [DATA_W-1:0] a_q, b_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;
    logic [RANK_W-1:0] rank_q;

    logic              a_hit, b_hit;
    logic [DATA_W-1:0] a_fwd, b_fwd;
    logic              a_ok, b_ok;
    logic              live;

    rs_snoop #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop_a (
        .tag_i(a_tag_q), .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
        .fwd_data(fwd_data), .hit_o(a_hit), .data_o(a_fwd)
    );

    rs_snoop #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop_b (
        .tag_i(b_tag_q), .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
        .fwd_data(fwd_data), .hit_o(b_hit), .data_o(b_fwd)
    );

    assign live = (st_q == ENT_WAIT) || (st_q == ENT_RDY);
    assign a_ok = a_v_q || a_hit;
    assign b_ok = b_v_q || b_hit;

    // Next-state decision
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = ENT_FREE;
        end else begin
            unique case (st_q)
                ENT_FREE: begin
                    if (alloc_i) begin
                        st_d = (d_a_ok && d_b_ok) ? ENT_RDY : ENT_WAIT;
                    end
                end
                ENT_WAIT, ENT_RDY: begin
                    if (grant_i) begin
                        st_d = exc_q ? ENT_HELD : ENT_FREE;
                    end else if (a_ok && b_ok) begin
                        st_d = ENT_RDY;
                    end else begin
                        st_d = ENT_WAIT;
                    end
                end
                ENT_HELD: begin
                    if (fin_hit_i) begin
                        st_d = ENT_FREE;
                    end else if (rpl_hit_i) begin
                        st_d = ENT_RDY;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ENT_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    // Payload, operand capture and rank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            dst_q   <= '0;
            exc_q   <= 1'b0;
            a_v_q   <= 1'b0;
            b_v_q   <= 1'b0;
            a_q     <= '0;
            b_q     <= '0;
            a_tag_q <= '0;
            b_tag_q <= '0;
            rank_q  <= '0;
        end else if (alloc_i && (st_q == ENT_FREE)) begin
            op_q    <= d_op;
            dst_q   <= d_dst;
            exc_q   <= d_exc;
            a_v_q   <= d_a_ok;
            b_v_q   <= d_b_ok;
            a_q     <= d_a_val;
            b_q     <= d_b_val;
            a_tag_q <= d_a_tag;
            b_tag_q <= d_b_tag;
            rank_q  <= d_rank;
        end else begin
            if (live && !a_v_q && a_hit) begin
                a_v_q <= 1'b1;
                a_q   <= a_fwd;
            end
            if (live && !b_v_q && b_hit) begin
                b_v_q <= 1'b1;
                b_q   <= b_fwd;
            end
            if (st_q != ENT_FREE) begin
                rank_q <= rank_q - rank_dec_i;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o  = (st_q != ENT_FREE);
        held_o  = (st_q == ENT_HELD);
        cand_o  = live && a_ok && b_ok;
        leave_o = (grant_i && !exc_q) || (fin_hit_i && (st_q == ENT_HELD));
        a_o     = a_v_q ? a_q : a_fwd;
        b_o     = b_v_q ? b_q : b_fwd;
        op_o    = op_q;
        dst_o   = dst_q;
        exc_o   = exc_q;
        rank_o  = rank_q;
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int NBUS   = 2,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   disp_valid,
    input  logic [OP_W-1:0]        disp_op,
    input  logic                   disp_may_exc,
    input  logic                   disp_a_ok,
    input  logic [DATA_W-1:0]      disp_a_val,
    input  logic [TAG_W-1:0]       disp_a_tag,
    input  logic                   disp_b_ok,
    input  logic [DATA_W-1:0]      disp_b_val,
    input  logic [TAG_W-1:0]       disp_b_tag,
    input  logic [TAG_W-1:0]       disp_dst,
    output logic                   disp_stall,
    input  logic [NBUS-1:0]        fwd_valid,
    input  logic [NBUS*TAG_W-1:0]  fwd_tag,
    input  logic [NBUS*DATA_W-1:0] fwd_data,
    output logic                   iss_valid,
    output logic [IDX_W-1:0]       iss_slot,
    output logic [OP_W-1:0]        iss_op,
    output logic [DATA_W-1:0]      iss_a,
    output logic [DATA_W-1:0]      iss_b,
    output logic [TAG_W-1:0]       iss_dst,
    output logic                   iss_held,
    input  logic                   fin_valid,
    input  logic [IDX_W-1:0]       fin_slot,
    input  logic                   rpl_valid,
    input  logic [IDX_W-1:0]       rpl_slot
);

    localparam int RANK_W = IDX_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]        busy_vec, held_vec, cand_vec, leave_vec, grant_vec, alloc_vec;
    logic [DATA_W-1:0]       a_arr   [DEPTH];
    logic [DATA_W-1:0]       b_arr   [DEPTH];
    logic [OP_W-1:0]         op_arr  [DEPTH];
    logic [TAG_W-1:0]        dst_arr [DEPTH];
    logic [DEPTH-1:0]        exc_vec;
    logic [RANK_W-1:0]       rank_arr [DEPTH];
    logic [RANK_W-1:0]       dec_arr  [DEPTH];
    logic [DEPTH*RANK_W-1:0] rank_flat;

    logic [IDX_W-1:0]  free_idx, sel_idx;
    logic              full, sel_valid, accept;
    logic              da_hit, db_hit;
    logic [DATA_W-1:0] da_fwd, db_fwd;
    logic              d_a_ok, d_b_ok;
    logic [DATA_W-1:0] d_a_val, d_b_val;
    logic [CNT_W-1:0]  keep_cnt;
    logic [RANK_W-1:0] new_rank;

    // Dispatch-time snoop so a result broadcast alongside dispatch is not lost
    rs_snoop #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dsnoop_a (
        .tag_i(disp_a_tag), .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
        .fwd_data(fwd_data), .hit_o(da_hit), .data_o(da_fwd)
    );

    rs_snoop #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dsnoop_b (
        .tag_i(disp_b_tag), .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
        .fwd_data(fwd_data), .hit_o(db_hit), .data_o(db_fwd)
    );

    assign d_a_ok  = disp_a_ok || da_hit;
    assign d_b_ok  = disp_b_ok || db_hit;
    assign d_a_val = disp_a_ok ? disp_a_val : da_fwd;
    assign d_b_val = disp_b_ok ? disp_b_val : db_fwd;

    rs_alloc #(.DEPTH(DEPTH)) u_alloc (
        .busy_i(busy_vec), .free_idx_o(free_idx), .full_o(full)
    );

    assign disp_stall = full;
    assign accept     = disp_valid && !full && !flush;

    // Age bookkeeping: younger entries close the gap left by freed ones
    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (busy_vec[i] && !leave_vec[i]) begin
                keep_cnt = keep_cnt + CNT_W'(1);
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            dec_arr[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (leave_vec[j] && (rank_arr[j] < rank_arr[i])) begin
                    dec_arr[i] = dec_arr[i] + RANK_W'(1);
                end
            end
        end
    end

    assign new_rank = RANK_W'(keep_cnt);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign alloc_vec[g] = accept && (free_idx == IDX_W'(g));
        assign rank_flat[g*RANK_W +: RANK_W] = rank_arr[g];

        rs_entry #(
            .NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .RANK_W(RANK_W)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .alloc_i    (alloc_vec[g]),
            .d_op       (disp_op),
            .d_exc      (disp_may_exc),
            .d_a_ok     (d_a_ok),
            .d_a_val    (d_a_val),
            .d_a_tag    (disp_a_tag),
            .d_b_ok     (d_b_ok),
            .d_b_val    (d_b_val),
            .d_b_tag    (disp_b_tag),
            .d_dst      (disp_dst),
            .d_rank     (new_rank),
            .fwd_valid  (fwd_valid),
            .fwd_tag    (fwd_tag),
            .fwd_data   (fwd_data),
            .grant_i    (grant_vec[g]),
            .fin_hit_i  (fin_valid && (fin_slot == IDX_W'(g))),
            .rpl_hit_i  (rpl_valid && (rpl_slot == IDX_W'(g))),
            .rank_dec_i (dec_arr[g]),
            .busy_o     (busy_vec[g]),
            .held_o     (held_vec[g]),
            .cand_o     (cand_vec[g]),
            .leave_o    (leave_vec[g]),
            .a_o        (a_arr[g]),
            .b_o        (b_arr[g]),
            .op_o       (op_arr[g]),
            .dst_o      (dst_arr[g]),
            .exc_o      (exc_vec[g]),
            .rank_o     (rank_arr[g])
        );
    end

    rs_select #(.DEPTH(DEPTH)) u_select (
        .cand_i  (cand_vec),
        .rank_i  (rank_flat),
        .en_i    (!flush),
        .valid_o (sel_valid),
        .idx_o   (sel_idx),
        .grant_o (grant_vec)
    );

    always_comb begin
        iss_valid = sel_valid;
        iss_slot  = sel_idx;
        iss_op    = op_arr[sel_idx];
        iss_a     = a_arr[sel_idx];
        iss_b     = b_arr[sel_idx];
        iss_dst   = dst_arr[sel_idx];
        iss_held  = exc_vec[sel_idx];
    end

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_slot,
    input logic             iss_held,
    input logic             fin_valid,
    input logic [IDX_W-1:0] fin_slot,
    input logic [DEPTH-1:0] busy_vec,
    input logic [DEPTH-1:0] held_vec,
    input logic [DEPTH-1:0] grant_vec
);

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R6

    AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_held && !flush) |=> held_vec[$past(iss_slot)]); // R7

    AST_PLAIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_held && !flush) |=> !busy_vec[$past(iss_slot)]); // R7

    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_valid && held_vec[fin_slot] && !flush) |=> !busy_vec[$past(fin_slot)]); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_vec == '0)); // R9

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_valid); // R9

endmodule

bind rs_station rs_station_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .iss_valid (iss_valid),
    .iss_slot  (iss_slot),
    .iss_held  (iss_held),
    .fin_valid (fin_valid),
    .fin_slot  (fin_slot),
    .busy_vec  (busy_vec),
    .held_vec  (held_vec),
    .grant_vec (grant_vec)
);

// File: tb/test_rs_station.sv
module test_rs_station;

    localparam int DEPTH  = 4;
    localparam int NBUS   = 2;
    localparam int TAG_W  = 5;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int IDX_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush;
    logic disp_valid, disp_may_exc, disp_a_ok, disp_b_ok;
    logic [OP_W-1:0] disp_op;
    logic [DATA_W-1:0] disp_a_val, disp_b_val;
    logic [TAG_W-1:0] disp_a_tag, disp_b_tag, disp_dst;
    logic disp_stall;
    logic [NBUS-1:0] fwd_valid;
    logic [NBUS*TAG_W-1:0] fwd_tag;
    logic [NBUS*DATA_W-1:0] fwd_data;
    logic iss_valid, iss_held;
    logic [IDX_W-1:0] iss_slot;
    logic [OP_W-1:0] iss_op;
    logic [DATA_W-1:0] iss_a, iss_b;
    logic [TAG_W-1:0] iss_dst;
    logic fin_valid, rpl_valid;
    logic [IDX_W-1:0] fin_slot, rpl_slot;

    always #10 clk = ~clk; // 50 MHz

    rs_station i_rs_station (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_may_exc(disp_may_exc),
        .disp_a_ok(disp_a_ok), .disp_a_val(disp_a_val), .disp_a_tag(disp_a_tag),
        .disp_b_ok(disp_b_ok), .disp_b_val(disp_b_val), .disp_b_tag(disp_b_tag),
        .disp_dst(disp_dst), .disp_stall(disp_stall),
        .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data),
        .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b), .iss_dst(iss_dst), .iss_held(iss_held),
        .fin_valid(fin_valid), .fin_slot(fin_slot),
        .rpl_valid(rpl_valid), .rpl_slot(rpl_slot)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    // Behavioural model: 0 free, 1 waiting for issue, 2 held after issue
    int m_st [DEPTH];
    bit m_aok [DEPTH];
    bit m_bok [DEPTH];
    int m_a [DEPTH];
    int m_b [DEPTH];
    int m_at [DEPTH];
    int m_bt [DEPTH];
    int m_op [DEPTH];
    int m_dst [DEPTH];
    bit m_exc [DEPTH];
    int m_age [DEPTH];
    int age_ctr = 0;

    bit e_valid, e_stall;
    int e_slot, e_a, e_b;

    task automatic bus_find(input int tag, output bit hit, output int val);
        hit = 1'b0;
        val = 0;
        for (int b = 0; b < NBUS; b++) begin
            if (!hit && fwd_valid[b] && int'(fwd_tag[b*TAG_W +: TAG_W]) == tag) begin
                hit = 1'b1;
                val = int'(fwd_data[b*DATA_W +: DATA_W]);
            end
        end
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_eval();
        int best_age;
        e_stall = 1'b1;
        e_valid = 1'b0;
        e_slot = 0; e_a = 0; e_b = 0;
        best_age = 0;
        for (int i = 0; i < DEPTH; i++) begin
            bit ha, hb;
            int va, vb;
            if (m_st[i] == 0) e_stall = 1'b0;
            if (m_st[i] == 1) begin
                bus_find(m_at[i], ha, va);
                bus_find(m_bt[i], hb, vb);
                if ((m_aok[i] || ha) && (m_bok[i] || hb) && !flush
                    && (!e_valid || m_age[i] < best_age)) begin
                    e_valid = 1'b1;
                    e_slot = i;
                    best_age = m_age[i];
                    e_a = m_aok[i] ? m_a[i] : va;
                    e_b = m_bok[i] ? m_b[i] : vb;
                end
            end
        end
    endtask

    task automatic compare();
        chk(disp_stall === e_stall, "disp_stall", int'(disp_stall), int'(e_stall));
        chk(iss_valid === e_valid, "iss_valid", int'(iss_valid), int'(e_valid));
        if (e_valid && iss_valid) begin
            chk(int'(iss_slot) == e_slot, "iss_slot (oldest)", int'(iss_slot), e_slot);
            chk(int'(iss_a) == e_a, "iss_a", int'(iss_a), e_a);
            chk(int'(iss_b) == e_b, "iss_b", int'(iss_b), e_b);
            chk(int'(iss_op) == m_op[e_slot], "iss_op", int'(iss_op), m_op[e_slot]);
            chk(int'(iss_dst) == m_dst[e_slot], "iss_dst", int'(iss_dst), m_dst[e_slot]);
            chk(iss_held === m_exc[e_slot], "iss_held R10", int'(iss_held), int'(m_exc[e_slot]));
        end
    endtask

    task automatic model_update();
        int pre [DEPTH];
        int free_i;
        for (int i = 0; i < DEPTH; i++) pre[i] = m_st[i];
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
            return;
        end
        free_i = -1;
        for (int i = 0; i < DEPTH; i++) if (pre[i] == 0 && free_i < 0) free_i = i;
        for (int i = 0; i < DEPTH; i++) begin
            if (pre[i] == 1 && !(e_valid && e_slot == i)) begin
                bit h;
                int v;
                if (!m_aok[i]) begin bus_find(m_at[i], h, v); if (h) begin m_aok[i] = 1; m_a[i] = v; end end
                if (!m_bok[i]) begin bus_find(m_bt[i], h, v); if (h) begin m_bok[i] = 1; m_b[i] = v; end end
            end
        end
        if (e_valid) begin
            if (m_exc[e_slot]) begin
                m_st[e_slot] = 2;
                m_aok[e_slot] = 1; m_a[e_slot] = e_a;
                m_bok[e_slot] = 1; m_b[e_slot] = e_b;
            end else begin
                m_st[e_slot] = 0;
            end
        end
        if (fin_valid && pre[fin_slot] == 2) m_st[fin_slot] = 0;
        if (rpl_valid && pre[rpl_slot] == 2 && !(fin_valid && fin_slot == rpl_slot))
            m_st[rpl_slot] = 1;
        if (disp_valid && free_i >= 0) begin
            bit h;
            int v;
            m_st[free_i] = 1;
            m_op[free_i] = int'(disp_op);
            m_dst[free_i] = int'(disp_dst);
            m_exc[free_i] = disp_may_exc;
            m_at[free_i] = int'(disp_a_tag);
            m_bt[free_i] = int'(disp_b_tag);
            m_aok[free_i] = disp_a_ok; m_a[free_i] = int'(disp_a_val);
            m_bok[free_i] = disp_b_ok; m_b[free_i] = int'(disp_b_val);
            if (!disp_a_ok) begin bus_find(m_at[free_i], h, v); if (h) begin m_aok[free_i] = 1; m_a[free_i] = v; end end
            if (!disp_b_ok) begin bus_find(m_bt[free_i], h, v); if (h) begin m_bok[free_i] = 1; m_b[free_i] = v; end end
            m_age[free_i] = age_ctr;
            age_ctr++;
        end
    endtask

    task automatic clear_inputs();
        flush = 0; disp_valid = 0; disp_op = '0; disp_may_exc = 0;
        disp_a_ok = 0; disp_a_val = '0; disp_a_tag = '0;
        disp_b_ok = 0; disp_b_val = '0; disp_b_tag = '0; disp_dst = '0;
        fwd_valid = '0; fwd_tag = '0; fwd_data = '0;
        fin_valid = 0; fin_slot = '0; rpl_valid = 0; rpl_slot = '0;
    endtask

    task automatic tick();
        #1;
        model_eval();
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic disp(input bit aok, input int a, input int at, input bit bok, input int b,
                        input int bt, input bit exc, input int op, input int dst);
        disp_valid = 1; disp_may_exc = exc; disp_op = OP_W'(op); disp_dst = TAG_W'(dst);
        disp_a_ok = aok; disp_a_val = DATA_W'(a); disp_a_tag = TAG_W'(at);
        disp_b_ok = bok; disp_b_val = DATA_W'(b); disp_b_tag = TAG_W'(bt);
    endtask

    task automatic bus(input int k, input int tag, input int val);
        fwd_valid[k] = 1'b1;
        fwd_tag[k*TAG_W +: TAG_W] = TAG_W'(tag);
        fwd_data[k*DATA_W +: DATA_W] = DATA_W'(val);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        clear_inputs();
        for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        cur_req = "R1";
        tick(); tick();

        // R2: fill with pending operands, then offer a fifth while stalled
        cur_req = "R2";
        disp(0, 0, 1, 1, 100, 0, 0, 1, 11); tick();
        disp(0, 0, 2, 1, 200, 0, 0, 2, 12); tick();
        disp(0, 0, 3, 1, 300, 0, 0, 3, 13); tick();
        disp(0, 0, 4, 1, 400, 0, 0, 4, 14); tick();
        disp(1, 9, 0, 1, 9, 0, 0, 5, 15); tick();   // dropped: stall high
        tick();

        // R5: tags 4 and 2 together; slot 1 is older and issues in the broadcast cycle
        cur_req = "R5";
        bus(0, 4, 1004); bus(1, 2, 1002); tick();
        // R6: slot 3 captured its value and follows
        cur_req = "R6";
        tick();
        bus(0, 3, 1003); bus(1, 1, 1001); tick();
        tick(); tick();

        // R3: ready operands, and a pending B woken later; two buses carry the same tag
        cur_req = "R3";
        disp(1, 55, 0, 1, 66, 0, 0, 6, 20); tick();
        disp(1, 77, 0, 0, 0, 7, 0, 7, 21); tick();
        tick();
        bus(1, 7, 2222); bus(0, 7, 1111); tick();
        tick();

        // R4: tag broadcast in the dispatch cycle
        cur_req = "R4";
        disp(0, 0, 9, 0, 0, 10, 0, 8, 22); bus(0, 9, 909); bus(1, 10, 1010); tick();
        tick(); tick();

        // R7 / R10: may-except instruction is held after issue
        cur_req = "R7";
        disp(1, 31, 0, 1, 32, 0, 1, 9, 23); tick();
        tick(); tick(); tick();
        // R8: finish naming a non-held slot is ignored
        cur_req = "R8";
        disp(0, 0, 12, 1, 5, 0, 0, 10, 24); tick();
        fin_valid = 1; fin_slot = 2'd1; tick();
        rpl_valid = 1; rpl_slot = 2'd0; tick();
        tick();
        fin_valid = 1; fin_slot = 2'd0; rpl_valid = 1; rpl_slot = 2'd0; tick();
        tick();
        bus(0, 12, 1212); tick();
        tick();

        // R9: flush with a dispatch offered in the same cycle
        cur_req = "R9";
        disp(0, 0, 14, 0, 0, 15, 0, 1, 1); tick();
        disp(1, 1, 0, 1, 2, 0, 1, 2, 2); tick();
        disp(1, 3, 0, 1, 4, 0, 0, 3, 3); flush = 1; tick();
        tick();
        cur_req = "R1";
        tick();

        // R6: random mix compared against the model every clock
        cur_req = "R6";
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 2) == 0)
                disp(($urandom % 3) == 0, $urandom % 65536, $urandom % 8,
                     ($urandom % 3) == 0, $urandom % 65536, $urandom % 8,
                     ($urandom % 4) == 0, $urandom % 16, $urandom % 32);
            for (int k = 0; k < NBUS; k++)
                if (($urandom % 5) < 2) bus(k, $urandom % 8, $urandom % 65536);
            if (($urandom % 7) == 0) begin fin_valid = 1; fin_slot = IDX_W'($urandom % DEPTH); end
            if (($urandom % 7) == 0) begin rpl_valid = 1; rpl_slot = IDX_W'($urandom % DEPTH); end
            if (($urandom % 100) == 0) flush = 1;
            tick();
        end

        summary();
        $finish;
    end

endmodule